// File: doc/BRIEF.md
# Floating-Point Control and Exception Flag Register Unit

This unit keeps the control and status state of a floating-point execution unit in three registers: a mode register, a read-only launch status register and an exception flag register. Scalar software reaches the registers through get and set operations. Each operation carries a 16-bit immediate that names a register and a contiguous bit field inside it. A read returns the field right-justified in the same cycle. A write merges the field into the register at the next clock edge.

A vector datapath reports exceptions per lane. The unit ORs those reports across all lanes and collects them into sticky flags, unless the clamp control bit in the mode register is set. The unit also drives the rounding, denormal and IEEE controls to the datapath. It raises a trap request when a flagged exception is also enabled in the mode register and traps are enabled globally.

Top module: `fpcsr_unit`

## Requirements
- R1: An access immediate holds the register id in bits 5:0, the field start bit in bits 10:6 and the field width in bits 15:11. A width of 0 means 32 bits. Field bits above bit 31 are dropped. A read returns `(reg & mask) >> start`, combinationally from the current register contents.
- R2: A write with `wr_en` high changes only the bits inside the selected field, to `wr_data` shifted left by the start bit. Every other bit of the register keeps its value.
- R3: Id 1 selects mode, id 2 selects status and id 3 selects exception flags. Reads of any other id return 0, and writes to any other id change nothing.
- R4: The datapath controls come from mode bits: `round_f32` = bits 1:0, `round_f64` = bits 3:2, `denorm_f32` = bits 5:4, `denorm_f64` = bits 7:6, `ieee_mode` = bit 9. The rounding codes are 0 nearest, 1 upward, 2 downward and 3 toward zero.
- R5: Only bits 5:0 of the exception flag register exist. From bit 0 upward they are invalid, denormal, divide-by-zero, overflow, underflow and inexact. Higher bits read as 0. A flag stays set until a write clears it.
- R6: Lane `l` reports on `lane_excp[l*6 +: 6]`, using the R5 bit order. The reports of all lanes are ORed together and set the flags at the next edge. When a write to the flag register lands in the same cycle, the reports are ORed in after the write.
- R7: The status register ignores writes. Its bit 6 is the global trap enable and is loaded from `trap_en_init` during reset. All its other bits read as 0.
- R8: `trap_req` is high exactly when status bit 6 is 1 and some flag bit k is also set in mode bit 12+k. Mode bits 17:12 form the trap enable field.
- R9: While mode bit 8 (clamp) is 1, lane reports are not recorded. The clamp value used is the one held before that cycle's edge.
- R10: During reset, the mode register and the flags clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_en_init | input | 1 | Value loaded into status bit 6 during reset |
| rd_imm | input | 16 | Read access immediate |
| rd_data | output | 32 | Right-justified read field |
| wr_en | input | 1 | Write strobe |
| wr_imm | input | 16 | Write access immediate |
| wr_data | input | 32 | Right-justified write value |
| lane_excp | input | LANES*6 | Per-lane exception pulses |
| round_f32 | output | 2 | Rounding mode, 32-bit operations |
| round_f64 | output | 2 | Rounding mode, 64/16-bit operations |
| denorm_f32 | output | 2 | Denormal mode, 32-bit operations |
| denorm_f64 | output | 2 | Denormal mode, 64/16-bit operations |
| ieee_mode | output | 1 | IEEE-compliant mode |
| trap_req | output | 1 | Trap request |

## Verification
The assertions check on every cycle that flags only fall after a write to the flag register, that the reports of an unclamped cycle show up in the flags, that a clamped cycle without a write leaves the flags alone, that the global enable never changes outside reset, that no trap is requested while it is off, and that unimplemented ids read zero. Only the bench's scenarios can show that field extraction and merging are correct for every width and offset, including truncation at bit 31. The same holds for the exact mapping of mode bits to the datapath controls, and for a clear and a new report landing in the same cycle.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
   localparam logic [5:0] ID_MODE = 6'd1;
   localparam logic [5:0] ID_STAT = 6'd2;
   localparam logic [5:0] ID_FLAG = 6'd3;
   localparam int TEN_BIT   = 6;
   localparam int CLAMP_BIT = 8;
   localparam int IEEE_BIT  = 9;
   localparam int EN_LSB    = 12;
   localparam int EN_SPAN   = 9;
endpackage

// File: rtl/fpcsr_field_decode.sv
module fpcsr_field_decode #(
   parameter int DW = 32
) (
   input  logic [15:0]   imm,
   output logic [DW-1:0] mask,
   output logic [4:0]    off,
   output logic [5:0]    id
);
   localparam int WW = $clog2(DW) + 1;

   if (DW != 32) begin : g_bad_dw
      $error("fpcsr_field_decode: DW must be 32 for a 5-bit width field");
   end

   logic [WW-1:0]   width;
   logic [2*DW-1:0] ones;

   always_comb begin
      off   = imm[10:6];
      id    = imm[5:0];
      width = (imm[15:11] == 5'd0) ? WW'(DW) : WW'(imm[15:11]);
      ones  = ~({(2*DW){1'b1}} << width);
      mask  = DW'(ones << off);
   end
endmodule

// File: rtl/fpcsr_lane_or.sv
module fpcsr_lane_or #(
   parameter int LANES = 4,
   parameter int XW    = 6
) (
   input  logic [LANES*XW-1:0] lane_excp,
   output logic [XW-1:0]       merged
);
   if (LANES < 1) begin : g_bad_lanes
      $error("fpcsr_lane_or: LANES must be at least 1");
   end

   if (LANES == 1) begin : g_single
      assign merged = lane_excp;
   end else begin : g_multi
      always_comb begin
         merged = '0;
         for (int l = 0; l < LANES; l++) begin
            merged = merged | lane_excp[l*XW +: XW];
         end
      end
   end
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit #(
   parameter int LANES       = 4,
   parameter int XW          = 6,
   parameter int DW          = 32,
   parameter bit CLAMP_GATES = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trap_en_init,
   input  logic [15:0]         rd_imm,
   output logic [31:0]         rd_data,
   input  logic                wr_en,
   input  logic [15:0]         wr_imm,
   input  logic [31:0]         wr_data,
   input  logic [LANES*6-1:0]  lane_excp,
   output logic [1:0]          round_f32,
   output logic [1:0]          round_f64,
   output logic [1:0]          denorm_f32,
   output logic [1:0]          denorm_f64,
   output logic                ieee_mode,
   output logic                trap_req
);
   import fpcsr_pkg::*;

   if (XW != 6) begin : g_bad_xw
      $error("fpcsr_unit: XW must be 6 (flag layout and lane port width)");
   end
   if (XW > EN_SPAN || XW > TEN_BIT) begin : g_bad_span
      $error("fpcsr_unit: flag field overlaps the status enable bit");
   end

   logic [DW-1:0] rd_mask, wr_mask;
   logic [4:0]    rd_off, wr_off;
   logic [5:0]    rd_id, wr_id;
   logic [XW-1:0] events;

   fpcsr_field_decode #(.DW(DW)) u_rd_dec (.imm(rd_imm), .mask(rd_mask), .off(rd_off), .id(rd_id));
   fpcsr_field_decode #(.DW(DW)) u_wr_dec (.imm(wr_imm), .mask(wr_mask), .off(wr_off), .id(wr_id));
   fpcsr_lane_or #(.LANES(LANES), .XW(XW)) u_lane_or (.lane_excp(lane_excp), .merged(events));

   logic [DW-1:0] mode_q, mode_d;
   logic [XW-1:0] trap_q, trap_d, trap_w;
   logic          ten_q;
   logic          record;
   logic [DW-1:0] wr_field, rd_sel;

   if (CLAMP_GATES) begin : g_clamp_gates
      assign record = ~mode_q[CLAMP_BIT];
   end else begin : g_clamp_free
      assign record = 1'b1;
   end

   always_comb begin
      wr_field = (DW'(wr_data) << wr_off) & wr_mask;
      mode_d   = mode_q;
      trap_w   = trap_q;
      if (wr_en && wr_id == ID_MODE) mode_d = (mode_q & ~wr_mask) | wr_field;
      if (wr_en && wr_id == ID_FLAG) trap_w = (trap_q & ~wr_mask[XW-1:0]) | wr_field[XW-1:0];
      trap_d = trap_w | (record ? events : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         trap_q <= '0;
         ten_q  <= trap_en_init;
      end else begin
         mode_q <= mode_d;
         trap_q <= trap_d;
         ten_q  <= ten_q;
      end
   end

   always_comb begin
      rd_sel = '0;
      case (rd_id)
         ID_MODE: rd_sel = mode_q;
         ID_STAT: rd_sel[TEN_BIT] = ten_q;
         ID_FLAG: rd_sel[XW-1:0] = trap_q;
         default: rd_sel = '0;
      endcase
      rd_data = 32'((rd_sel & rd_mask) >> rd_off);
   end

   assign round_f32  = mode_q[1:0];
   assign round_f64  = mode_q[3:2];
   assign denorm_f32 = mode_q[5:4];
   assign denorm_f64 = mode_q[7:6];
   assign ieee_mode  = mode_q[IEEE_BIT];
   assign trap_req   = ten_q & (|(trap_q & mode_q[EN_LSB +: XW]));
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker #(
   parameter int LANES       = 4,
   parameter int XW          = 6,
   parameter bit CLAMP_GATES = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [5:0]          wr_id,
   input logic [5:0]          rd_id,
   input logic [31:0]         rd_data,
   input logic [LANES*XW-1:0] lane_excp,
   input logic [XW-1:0]       flags,
   input logic                ten,
   input logic                clamp,
   input logic                trap_req
);
   logic [XW-1:0] ev_any;
   logic          flag_wr;

   always_comb begin
      ev_any = '0;
      for (int l = 0; l < LANES; l++) ev_any = ev_any | lane_excp[l*XW +: XW];
      flag_wr = wr_en && (wr_id == 6'd3);
   end

   // R5: flags only fall after a flag write
   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_wr) |-> ((flags & $past(flags)) == $past(flags)));

   // R6: unclamped lane reports reach the flags
   a_r6_record: assert property (@(posedge clk) disable iff (!rst_n)
      (!CLAMP_GATES || !$past(clamp)) |-> ((flags & $past(ev_any)) == $past(ev_any)));

   // R9: clamp holds the flags when no write lands
   a_r9_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (CLAMP_GATES && $past(clamp) && !$past(flag_wr)) |-> (flags == $past(flags)));

   // R7: global enable is fixed outside reset
   a_r7_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ten));

   // R8: no trap while global enable is off
   a_r8_trap_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !ten |-> !trap_req);

   // R3: unimplemented ids read zero
   a_r3_unimpl_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_id == 6'd0 || rd_id > 6'd3) |-> (rd_data == 32'd0));
endmodule

bind fpcsr_unit fpcsr_checker #(.LANES(LANES), .XW(XW), .CLAMP_GATES(CLAMP_GATES)) u_fpcsr_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_id(wr_imm[5:0]), .rd_id(rd_imm[5:0]),
   .rd_data(rd_data), .lane_excp(lane_excp), .flags(trap_q), .ten(ten_q),
   .clamp(mode_q[8]), .trap_req(trap_req));

// File: tb/test_fpcsr_unit.sv
module test_fpcsr_unit;
   localparam int LANES = 4;
   localparam int STEPS = 3000;

   logic clk = 1'b0, rst_n = 1'b0, trap_en_init = 1'b1;
   logic [15:0] rd_imm = '0, wr_imm = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic wr_en = 1'b0;
   logic [LANES*6-1:0] lane_excp = '0;
   logic [1:0] round_f32, round_f64, denorm_f32, denorm_f64;
   logic ieee_mode, trap_req;

   int vectors = 0, errors = 0, cycles = 0;
   bit done = 1'b0;

   logic [31:0] m_mode;
   logic [5:0]  m_flag;
   logic        m_ten;

   always #10 clk = ~clk;

   fpcsr_unit #(.LANES(LANES)) i_fpcsr_unit (
      .clk(clk), .rst_n(rst_n), .trap_en_init(trap_en_init), .rd_imm(rd_imm), .rd_data(rd_data),
      .wr_en(wr_en), .wr_imm(wr_imm), .wr_data(wr_data), .lane_excp(lane_excp),
      .round_f32(round_f32), .round_f64(round_f64), .denorm_f32(denorm_f32),
      .denorm_f64(denorm_f64), .ieee_mode(ieee_mode), .trap_req(trap_req));

   function automatic logic [31:0] b_mask(input logic [15:0] imm);
      int w = (imm[15:11] == 0) ? 32 : int'(imm[15:11]);
      logic [63:0] ones = (64'd1 << w) - 64'd1;
      return 32'(ones << imm[10:6]);
   endfunction

   function automatic logic [31:0] b_read(input logic [15:0] imm);
      logic [31:0] r = '0;
      case (imm[5:0])
         6'd1: r = m_mode;
         6'd2: r = 32'(m_ten) << 6;
         6'd3: r = {26'd0, m_flag};
         default: r = '0;
      endcase
      return (r & b_mask(imm)) >> imm[10:6];
   endfunction

   function automatic logic [15:0] mk(input int sz, input int off, input int id);
      return {5'(sz), 5'(off), 6'(id)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outputs();
      check("R4 round_f32", 32'(round_f32), 32'(m_mode[1:0]));
      check("R4 round_f64", 32'(round_f64), 32'(m_mode[3:2]));
      check("R4 denorm_f32", 32'(denorm_f32), 32'(m_mode[5:4]));
      check("R4 denorm_f64", 32'(denorm_f64), 32'(m_mode[7:6]));
      check("R4 ieee_mode", 32'(ieee_mode), 32'(m_mode[9]));
      check("R8 trap_req", 32'(trap_req), 32'(m_ten & (|(m_flag & m_mode[17:12]))));
   endtask

   // one cycle: drive at negedge, check read of present state, clock, update model
   task automatic step(input logic we, input logic [15:0] wi, input logic [31:0] wd,
                       input logic [15:0] ri, input logic [LANES*6-1:0] le, input string tag);
      logic [5:0] ev;
      logic [31:0] msk;
      logic old_clamp;
      @(negedge clk);
      wr_en = we; wr_imm = wi; wr_data = wd; rd_imm = ri; lane_excp = le;
      #2;
      check(tag, rd_data, b_read(ri));
      check_outputs();
      @(posedge clk);
      ev = '0;
      for (int l = 0; l < LANES; l++) ev = ev | le[l*6 +: 6];
      old_clamp = m_mode[8];
      msk = b_mask(wi);
      if (we && wi[5:0] == 6'd1) m_mode = (m_mode & ~msk) | ((wd << wi[10:6]) & msk);
      if (we && wi[5:0] == 6'd3) m_flag = (m_flag & ~msk[5:0]) | 6'((wd << wi[10:6]) & msk);
      if (!old_clamp) m_flag = m_flag | ev;
   endtask

   task automatic do_reset(input logic init);
      @(negedge clk);
      rst_n = 1'b0; trap_en_init = init;
      wr_en = 1'b0; lane_excp = '0;
      m_mode = '0; m_flag = '0; m_ten = init;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7719));
      do_reset(1'b1);
      // R10, R7: reset state
      step(0, 0, 0, mk(0, 0, 1), '0, "R10 mode reset");
      step(0, 0, 0, mk(0, 0, 3), '0, "R10 flags reset");
      step(0, 0, 0, mk(1, 6, 2), '0, "R7 trap enable from pin");
      // R4: round field per precision
      step(1, mk(2, 0, 1), 32'h3, mk(4, 0, 1), '0, "R4 round write");
      step(1, mk(2, 2, 1), 32'h2, mk(4, 0, 1), '0, "R4 round write f64");
      step(0, 0, 0, mk(4, 0, 1), '0, "R2 round field merged");
      // R1: width 0 full write, truncation at bit 31
      step(1, mk(0, 0, 1), 32'h0000_0000, mk(0, 0, 1), '0, "R1 full clear");
      step(1, mk(8, 28, 1), 32'hFF, mk(0, 0, 1), '0, "R1 truncated write");
      step(0, 0, 0, mk(8, 28, 1), '0, "R1 truncated read");
      step(1, mk(0, 0, 1), 32'h0, mk(0, 0, 1), '0, "R1 clear again");
      // R3, R7: ignored writes
      step(1, mk(0, 0, 2), 32'h0, mk(0, 0, 2), '0, "R7 status write");
      step(1, mk(0, 0, 5), 32'hFFFF_FFFF, mk(0, 0, 2), '0, "R7 status unchanged");
      step(0, 0, 0, mk(0, 0, 5), '0, "R3 unimplemented read");
      step(0, 0, 0, mk(0, 0, 1), '0, "R3 mode untouched by id 5");
      // R6, R5: lane OR and stickiness
      step(0, 0, 0, mk(0, 0, 3), 24'h000_0_41, "R6 lane report");
      step(0, 0, 0, mk(0, 0, 3), 24'h200_000, "R5 sticky");
      step(0, 0, 0, mk(0, 0, 3), '0, "R6 lane OR result");
      // R8: enable overflow traps (bit 3 -> mode bit 15)
      step(1, mk(6, 12, 1), 32'h08, mk(0, 0, 3), '0, "R8 enable write");
      step(0, 0, 0, mk(0, 0, 3), 24'h8, "R8 overflow report");
      step(0, 0, 0, mk(0, 0, 3), '0, "R8 trap raised");
      // R6: clear and new report in the same cycle
      step(1, mk(6, 0, 3), 32'h0, mk(0, 0, 3), 24'h10, "R6 clear with report");
      step(0, 0, 0, mk(0, 0, 3), '0, "R6 report after clear");
      // R9: clamp blocks recording
      step(1, mk(1, 8, 1), 32'h1, mk(0, 0, 3), 24'h1, "R9 set clamp");
      step(0, 0, 0, mk(0, 0, 3), 24'h3F, "R9 clamped report");
      step(0, 0, 0, mk(0, 0, 3), '0, "R9 flags unchanged");
      step(1, mk(1, 8, 1), 32'h0, mk(0, 0, 3), 24'h4, "R9 clamp still old value");
      step(0, 0, 0, mk(0, 0, 3), '0, "R9 clamp off");
      // R7: reset with pin low
      do_reset(1'b0);
      step(1, mk(0, 0, 1), 32'hFFFF_FFFF, mk(0, 0, 2), '0, "R7 enable low");
      step(1, mk(0, 0, 3), 32'h3F, mk(0, 0, 3), '0, "R8 no trap when disabled");
      step(0, 0, 0, mk(0, 0, 3), '0, "R8 no trap when disabled");
      do_reset(1'b1);
      // random mix
      for (int i = 0; i < STEPS; i++) begin
         logic [15:0] wi = 16'($urandom);
         logic [15:0] ri = 16'($urandom);
         logic [LANES*6-1:0] le = '0;
         wi[5:0] = 6'($urandom % 5);
         ri[5:0] = 6'($urandom % 5);
         if ($urandom % 4 == 0) le = LANES*6'($urandom & $urandom & $urandom);
         step(1'($urandom % 2), wi, $urandom, ri, le, "R1 R2 R5 random read");
      end
      step(0, 0, 0, 0, '0, "R4 final");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule